// File: doc/BRIEF.md
# Dual-Width Floating-Point Register File

This block holds the floating-point architectural registers of a core: a bank of 64-bit entries with one combinational read port and one clocked write port. Each port moves either a 32-bit word or a full 64-bit value, chosen per access by a size input.

A status input, `wide_mode`, sets how register numbers map to storage. When it is high, every register number names its own 64-bit entry. A word access then uses the low 32 bits of that entry. When it is low, registers pair up. An even number names an entry's low word and the odd number above it names the high word of that same entry. A 64-bit access then drops the lowest index bit. The same storage serves both views, so flipping the mode reinterprets values already held. Nothing is forwarded, and instruction fields are decoded elsewhere.

Top module: `fprf`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears every entry to zero and takes priority over a write in the same cycle.
- R2: With `wide_mode`=1, a word access (size input 0) to register x uses bits 31:0 of entry x. A word read returns that word on `rd_data[31:0]` and drives `rd_data[63:32]` to zero.
- R3: With `wide_mode`=0, a word access to an even register x uses bits 31:0 of entry x.
- R4: With `wide_mode`=0, a word access to an odd register x uses bits 63:32 of entry x-1.
- R5: A word write takes its value from `wr_data[31:0]` and leaves the other 32-bit half of the addressed entry unchanged.
- R6: With `wide_mode`=0, a 64-bit access (size input 1) to register x uses the whole of entry x with bit 0 cleared.
- R7: With `wide_mode`=1, a 64-bit access to register x uses the whole of entry x.
- R8: Writes take effect at the rising clock edge. A read of the location being written in the same cycle returns the old contents.
- R9: When `wr_en` is 0, no entry changes.
- R10: The mode is applied per access and not stored with the data, so data written under one mode is read back through the other mode's mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: one 64-bit entry per register number; 0: paired 32-bit view |
| rd_idx | input | 5 | Read register number |
| rd_dbl | input | 1 | Read size: 1 = 64-bit, 0 = 32-bit word |
| rd_data | output | 64 | Read value (word reads zero-extended) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_dbl | input | 1 | Write size: 1 = 64-bit, 0 = 32-bit word |
| wr_data | input | 64 | Write value (word writes use bits 31:0) |

## Verification
The bench builds the block with its default parameters: thirty-two registers and 32-bit halves. At this size every register number can be reached, including the top odd register 31, which pairs with entry 30. Random traffic runs through all four size-and-mode combinations at index 31 as well as at index 0. The same setting lets the bench flip `wide_mode` over live data, which shows that the two views share storage.

// File: rtl/fprf_pkg.sv
// Package: shared types for the floating-point register file.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package fprf_pkg;

    // Which 32-bit lanes of one storage entry an access touches.
    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_LO   = 2'b01,
        LANE_HI   = 2'b10,
        LANE_BOTH = 2'b11
    } lane_sel_e;

endpackage

// File: rtl/fprf_locate.sv
// Module: fprf_locate
// Maps an architectural register number, an access size and the mode
// bit onto a storage entry and the lanes of it that are used.
// Assumes NUM_REGS is even so every odd number has an even partner.
module fprf_locate
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] reg_num,
    input  logic             is_dbl,
    input  logic             wide,
    output logic [IDX_W-1:0] entry,
    output lane_sel_e        lanes
);

    logic [IDX_W-1:0] even_num;

    // Partner entry with the low index bit forced to zero.
    always_comb begin
        even_num    = reg_num;
        even_num[0] = 1'b0;
    end

    // Choose entry and lanes from size and mode.
    always_comb begin
        if (is_dbl) begin
            entry = wide ? reg_num : even_num;
            lanes = LANE_BOTH;
        end else if (wide) begin
            entry = reg_num;
            lanes = LANE_LO;
        end else begin
            entry = even_num;
            lanes = reg_num[0] ? LANE_HI : LANE_LO;
        end
    end

endmodule

// File: rtl/fprf_store.sv
// Module: fprf_store
// Storage array of NUM_REGS entries, each split into two independently
// writable halves. Writes happen on the rising edge; reset is
// synchronous, active low, and beats a write.
module fprf_store
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FULL_W  = 2 * HALF_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_entry,
    input  lane_sel_e                        wr_lanes,
    input  logic [HALF_W-1:0]                wr_lo,
    input  logic [HALF_W-1:0]                wr_hi,
    output logic [NUM_REGS-1:0][FULL_W-1:0]  entries
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic hit;
        logic lo_we;
        logic hi_we;

        // Decode whether this entry and each of its halves is written.
        always_comb begin
            hit   = wr_en && (wr_entry == IDX_W'(g));
            lo_we = hit && wr_lanes[0];
            hi_we = hit && wr_lanes[1];
        end

        // Low half register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g][HALF_W-1:0] <= '0;
            end else if (lo_we) begin
                entries[g][HALF_W-1:0] <= wr_lo;
            end
        end

        // High half register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g][FULL_W-1:HALF_W] <= '0;
            end else if (hi_we) begin
                entries[g][FULL_W-1:HALF_W] <= wr_hi;
            end
        end
    end

endmodule

// File: rtl/fprf_rdmux.sv
// Module: fprf_rdmux
// Combinational read selection: picks one entry and returns either the
// full value or one half zero-extended into the low lane.
module fprf_rdmux
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FULL_W  = 2 * HALF_W
) (
    input  logic [NUM_REGS-1:0][FULL_W-1:0] entries,
    input  logic [IDX_W-1:0]                rd_entry,
    input  lane_sel_e                       rd_lanes,
    output logic [FULL_W-1:0]               rd_value
);

    logic [FULL_W-1:0] picked;

    // Entry select.
    always_comb begin
        picked = entries[rd_entry];
    end

    // Lane shaping of the selected entry.
    always_comb begin
        unique case (rd_lanes)
            LANE_BOTH: rd_value = picked;
            LANE_LO:   rd_value = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
            LANE_HI:   rd_value = {{HALF_W{1'b0}}, picked[FULL_W-1:HALF_W]};
            default:   rd_value = '0;
        endcase
    end

endmodule

// File: rtl/fprf.sv
// Module: fprf (top)
// Floating-point register file, one combinational read port and one
// clocked write port, each 32- or 64-bit wide per access, with a mode
// input choosing one-entry-per-number or paired 32-bit numbering.
// Assumes NUM_REGS is an even power of two.
module fprf
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FULL_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_dbl,
    output logic [FULL_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_dbl,
    input  logic [FULL_W-1:0] wr_data
);

    logic [IDX_W-1:0]                rd_entry;
    lane_sel_e                       rd_lanes;
    logic [IDX_W-1:0]                wr_entry;
    lane_sel_e                       wr_lanes;
    logic [HALF_W-1:0]               wr_hi_in;
    logic [NUM_REGS-1:0][FULL_W-1:0] entries;

    fprf_locate #(.NUM_REGS(NUM_REGS)) u_rd_loc (
        .reg_num (rd_idx),
        .is_dbl  (rd_dbl),
        .wide    (wide_mode),
        .entry   (rd_entry),
        .lanes   (rd_lanes)
    );

    fprf_locate #(.NUM_REGS(NUM_REGS)) u_wr_loc (
        .reg_num (wr_idx),
        .is_dbl  (wr_dbl),
        .wide    (wide_mode),
        .entry   (wr_entry),
        .lanes   (wr_lanes)
    );

    // A word write lands in whichever half is enabled, so feed the low
    // word to the high half too when the access is 32-bit.
    always_comb begin
        wr_hi_in = wr_dbl ? wr_data[FULL_W-1:HALF_W] : wr_data[HALF_W-1:0];
    end

    fprf_store #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .wr_lanes (wr_lanes),
        .wr_lo    (wr_data[HALF_W-1:0]),
        .wr_hi    (wr_hi_in),
        .entries  (entries)
    );

    fprf_rdmux #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_rdmux (
        .entries  (entries),
        .rd_entry (rd_entry),
        .rd_lanes (rd_lanes),
        .rd_value (rd_data)
    );

endmodule

// File: rtl/fprf_checker.sv
// Module: fprf_checker
// Port-level properties of the register file, bound onto the top.
module fprf_checker #(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FULL_W  = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_dbl,
    input logic [FULL_W-1:0] rd_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_dbl,
    input logic [FULL_W-1:0] wr_data
);

    // Word reads never carry data in the upper lane.
    assert_word_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_dbl |-> rd_data[FULL_W-1:HALF_W] == '0);

    // Wide-mode word write is visible at the same number next cycle.
    assert_wide_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dbl && wide_mode) ##1
        (!rd_dbl && wide_mode && rd_idx == $past(wr_idx))
        |-> rd_data[HALF_W-1:0] == $past(wr_data[HALF_W-1:0]));

    // Paired odd word write shows up in the high lane of the pair.
    assert_odd_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dbl && !wide_mode && wr_idx[0]) ##1
        (rd_dbl && !wide_mode && rd_idx[IDX_W-1:1] == $past(wr_idx[IDX_W-1:1]))
        |-> rd_data[FULL_W-1:HALF_W] == $past(wr_data[HALF_W-1:0]));

    // Paired 64-bit accesses ignore the low index bit.
    assert_pair_dbl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && !wide_mode) ##1
        (rd_dbl && !wide_mode && rd_idx[IDX_W-1:1] == $past(wr_idx[IDX_W-1:1]))
        |-> rd_data == $past(wr_data));

    // Wide 64-bit write reads back whole at the same number.
    assert_wide_dbl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && wide_mode) ##1
        (rd_dbl && wide_mode && rd_idx == $past(wr_idx))
        |-> rd_data == $past(wr_data));

    // With writes disabled and the read inputs held, read data holds.
    assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) ##1 ($stable(rd_idx) && $stable(rd_dbl) && $stable(wide_mode))
        |-> $stable(rd_data));

endmodule

bind fprf fprf_checker #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_fprf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .rd_idx    (rd_idx),
    .rd_dbl    (rd_dbl),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_dbl    (wr_dbl),
    .wr_data   (wr_data)
);

// File: tb/fprf_bench.sv
`timescale 1ns/100ps
// Bench: behavioural reference model compared with the read port
// every cycle, directed cases first, then random traffic.
module fprf_bench;

    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wide_mode;
    logic [4:0]  rd_idx;
    logic        rd_dbl;
    logic [63:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic        wr_dbl;
    logic [63:0] wr_data;

    int total = 0;
    int bad   = 0;
    logic [63:0] model [NR];

    fprf u_fprf (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .rd_idx(rd_idx), .rd_dbl(rd_dbl), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dbl(wr_dbl), .wr_data(wr_data)
    );

    always #2.5 clk = ~clk;

    // Expected read value from the requirement mapping.
    function automatic logic [63:0] ref_read(int x, bit dbl, bit wide);
        if (dbl) return wide ? model[x] : model[x - (x % 2)];
        if (wide || (x % 2 == 0)) return {32'h0, model[x][31:0]};
        return {32'h0, model[x - 1][63:32]};
    endfunction

    // Model update for one write.
    task automatic ref_write(int x, bit dbl, bit wide, logic [63:0] d);
        if (dbl) begin
            if (wide) model[x] = d; else model[x - (x % 2)] = d;
        end else if (wide || (x % 2 == 0)) begin
            model[x][31:0] = d[31:0];
        end else begin
            model[x - 1][63:32] = d[31:0];
        end
    endtask

    function automatic string tag_for(int x, bit dbl, bit wide);
        if (dbl) return wide ? "R7" : "R6";
        if (wide) return "R2";
        return (x % 2 == 0) ? "R3" : "R4";
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before the edge, update model.
    task automatic step(int rx, bit rdbl, bit we, int wx, bit wdbl,
                        logic [63:0] wd, bit wide, string tag);
        rd_idx = 5'(rx); rd_dbl = rdbl; wr_en = we; wr_idx = 5'(wx);
        wr_dbl = wdbl; wr_data = wd; wide_mode = wide;
        #1;
        check(tag, rd_data, ref_read(rx, rdbl, wide));
        @(posedge clk);
        if (we && rst_n) ref_write(wx, wdbl, wide, wd);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        rst_n = 1'b0; wide_mode = 1'b1; rd_idx = '0; rd_dbl = 1'b1;
        // R1: a write held during reset must not land.
        wr_en = 1'b1; wr_idx = 5'd4; wr_dbl = 1'b1; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every entry reads zero after reset.
        for (int i = 0; i < NR; i++) step(i, 1, 0, 0, 0, 0, 1, "R1");

        // R7 / R2: wide 64-bit write, then word read of same number.
        step(0, 1, 1, 5, 1, 64'h1111_2222_3333_4444, 1, "R7");
        step(5, 1, 0, 0, 0, 0, 1, "R7");
        step(5, 0, 0, 0, 0, 0, 1, "R2");
        // R5: word write keeps the high half.
        step(0, 0, 1, 5, 0, 64'hFFFF_FFFF_AAAA_5555, 1, "R5");
        step(5, 1, 0, 0, 0, 0, 1, "R5");
        // R3 / R4: paired word writes into the pair 6/7.
        step(0, 0, 1, 6, 0, 64'h0000_0000_CAFE_0006, 0, "R3");
        step(0, 0, 1, 7, 0, 64'h0000_0000_BEEF_0007, 0, "R4");
        step(7, 0, 0, 0, 0, 0, 0, "R4");
        step(6, 0, 0, 0, 0, 0, 0, "R3");
        step(6, 1, 0, 0, 0, 0, 0, "R5");
        // R6: paired 64-bit write to odd number lands in the even entry.
        step(0, 0, 1, 31, 1, 64'h0123_4567_89AB_CDEF, 0, "R6");
        step(31, 1, 0, 0, 0, 0, 0, "R6");
        step(30, 1, 0, 0, 0, 0, 0, "R6");
        step(31, 0, 0, 0, 0, 0, 0, "R4");
        // R8: same-cycle read returns old, next cycle returns new.
        step(9, 1, 1, 9, 1, 64'h9999_8888_7777_6666, 1, "R8");
        step(9, 1, 0, 0, 0, 0, 1, "R8");
        // R9: write enable low leaves contents alone.
        step(9, 1, 0, 9, 1, 64'h5A5A_5A5A_5A5A_5A5A, 1, "R9");
        step(9, 1, 0, 0, 0, 0, 1, "R9");
        // R10: wide-written entry 2 viewed through the paired map.
        step(0, 0, 1, 2, 1, 64'hA1A2_A3A4_B1B2_B3B4, 1, "R10");
        step(3, 0, 0, 0, 0, 0, 0, "R10");
        step(3, 0, 0, 0, 0, 0, 1, "R10");

        // Random traffic across both modes and sizes.
        for (int n = 0; n < 4000; n++) begin
            int  rx = $urandom_range(0, NR - 1);
            bit  rd = 1'($urandom);
            bit  md = 1'($urandom);
            step(rx, rd, 1'($urandom), $urandom_range(0, NR - 1), 1'($urandom),
                 {$urandom, $urandom}, md, tag_for(rx, rd, md));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule